// File: doc/BRIEF.md
# Inverter Adapter Gate and Status Interface

This block connects a motor controller to a three-phase inverter adapter board. It passes six gate-drive signals to the board. Those signals pass only while a software-controlled gate enable is set, and that enable is clear after reset. The board reports six over-current flags, six fault flags and four current-amplifier diagnostic flags, all active low. The block synchronises these flags, inverts them to active-high status bits and packs them into one 32-bit status word. Over-current and fault flags are sticky, so a short pulse is still visible at the next software read.

The board also reports six switch temperatures as PWM signals. For each line the block measures the high time and the period between consecutive rising edges, in clock cycles. It turns them into a Q0.16 duty fraction with a per-channel serial divider. When a line stops toggling for a programmable number of cycles, the channel reports a saturated duty and a stale flag. Software converts the duty to a temperature. A flat write port and a combinational read port give access to the control word, the timeout, the status word and the six duty values.

Top module: `invadp_core`

## Requirements
- R1: `gate_o` repeats `gate_in` one clock later while the enable is set, and is all zero while it is clear. The bit order is [0]=H1, [1]=L1, [2]=H2, [3]=L2, [4]=H3, [5]=L3.
- R2: Control word, address 0, bit 0 is the gate enable. It resets to 0 and changes only by a write to address 0. `gate_en_o` and a read of bit 0 both show it.
- R3: Status word, address 2, with 1 meaning asserted: bits 5:0 over-current, bits 11:6 fault, bits 15:12 diagnostic (i1, i2, i3, DC in that order), bits 21:16 stale. The diagnostic bits follow the inverted inputs live.
- R4: An over-current or fault bit is set when its active-low input goes low, including for a single clock. It stays set after the input returns high.
- R5: Writing 1 to address 0 bit 1 clears all over-current and fault bits whose input is no longer low. A bit whose input is still low stays set.
- R6: The duty register at address 3+k (k = 0..5, same channel order as R1) holds floor(H*65536/P) in bits 15:0. H is the high cycles and P the period cycles of the last complete period between rising edges. The first rising edge after reset or after a stale event only arms the measurement.
- R7: The timeout word at address 1 resets to 1,000,000 and reads back as written. If a line shows no edge for that many cycles, its duty becomes 0xFFFF when the line is high or 0 when it is low, and its stale bit sets. The stale bit clears on the next completed measurement. A timeout of 0 disables this.
- R8: Reads of unmapped addresses return 0, and control bit 1 always reads 0.
- R9: After reset the gate enable, the gate outputs, the status word and all duty values are 0.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (100 MHz in the system) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| gate_in | input | 6 | Gate commands from the modulator |
| gate_o | output | 6 | Gate signals to the board |
| gate_en_o | output | 1 | Gate enable to the board, active high |
| oc_n_i | input | 6 | Over-current flags, active low |
| flt_n_i | input | 6 | Fault flags, active low |
| diag_n_i | input | 4 | Amplifier diagnostic flags, active low |
| temp_pwm_i | input | 6 | PWM temperature feedback lines |

## Verification
The assertions check on every cycle the properties that must hold at every clock:
- a gate output is never high while the enable is low;
- the enable never rises without a control write in the cycle before;
- a sticky flag never drops without a clear request;
- a stale channel always shows one of the two saturated duty values;
- a fresh measurement is never the saturated-high value.

The bench scenarios cover what those properties cannot express. They compare the divided duty against the exact quotient for random high times and periods. They show that one-cycle flag pulses survive and that a clear leaves still-asserted flags set. They also cover the timeout's effect on level and stale state, and the timeout-disable case.

// File: rtl/invadp_pkg.sv
package invadp_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int N_SW   = 6;
  localparam int N_DIAG = 4;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_TMO   = 4'd1;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd2;
  localparam logic [ADDR_W-1:0] A_DUTY0 = 4'd3;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_CLR_BIT = 1;

  typedef struct packed {
    logic [DATA_W-2*N_SW-N_DIAG-N_SW-1:0] rsvd;
    logic [N_SW-1:0]   stale;
    logic [N_DIAG-1:0] diag;
    logic [N_SW-1:0]   flt;
    logic [N_SW-1:0]   oc;
  } stat_word_t;
endpackage

// File: rtl/invadp_sync.sv
module invadp_sync #(
  parameter int W       = 1,
  parameter bit RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {W{RST_VAL}};
      sync_q <= {W{RST_VAL}};
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/invadp_flag.sv
module invadp_flag #(
  parameter int W      = 6,
  parameter bit STICKY = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_n,
  input  logic         clr,
  output logic [W-1:0] act,
  output logic [W-1:0] lat
);
  logic [W-1:0] act_q, act_d;

  assign act_d = ~raw_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  assign act = act_q;

  generate
    if (STICKY) begin : g_sticky
      logic [W-1:0] lat_q, lat_d;
      always_comb begin
        if (clr) lat_d = act_q;
        else     lat_d = lat_q | act_q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
      end
      assign lat = lat_q;
    end else begin : g_live
      logic unused_clr;
      assign unused_clr = clr;
      assign lat = act_q;
    end
  endgenerate
endmodule

// File: rtl/invadp_duty_meter.sv
module invadp_duty_meter #(
  parameter int CNT_W  = 24,
  parameter int FRAC_W = 16,
  parameter int TMO_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl,
  input  logic [TMO_W-1:0]  timeout,
  output logic [FRAC_W-1:0] duty,
  output logic              stale
);
  localparam int BIT_W = $clog2(FRAC_W + 1);

  logic              prev_q, prev_d;
  logic              armed_q, armed_d;
  logic [CNT_W-1:0]  per_q, per_d, hi_q, hi_d, idle_q, idle_d;
  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  rem_q, rem_d, den_q, den_d;
  logic [FRAC_W-1:0] quo_q, quo_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [FRAC_W-1:0] duty_q, duty_d;
  logic              stale_q, stale_d;

  logic              rise, toggle, to_hit;
  logic [CNT_W:0]    shifted;

  assign rise   = lvl & ~prev_q;
  assign toggle = lvl ^ prev_q;
  assign to_hit = (timeout != '0) && !toggle &&
                  ((TMO_W'(idle_q) + TMO_W'(1)) == timeout);
  assign shifted = {rem_q, 1'b0};

  always_comb begin
    prev_d  = lvl;
    armed_d = armed_q;
    per_d   = per_q;
    hi_d    = hi_q;
    idle_d  = idle_q;
    busy_d  = busy_q;
    rem_d   = rem_q;
    den_d   = den_q;
    quo_d   = quo_q;
    bit_d   = bit_q;
    duty_d  = duty_q;
    stale_d = stale_q;

    if (toggle)             idle_d = '0;
    else if (idle_q != '1)  idle_d = idle_q + 1'b1;

    if (rise) begin
      per_d = CNT_W'(1);
      hi_d  = CNT_W'(1);
    end else begin
      if (per_q != '1)        per_d = per_q + 1'b1;
      if (lvl && hi_q != '1)  hi_d  = hi_q + 1'b1;
    end

    if (rise) begin
      armed_d = 1'b1;
      if (armed_q) begin
        busy_d = 1'b1;
        rem_d  = hi_q;
        den_d  = per_q;
        quo_d  = '0;
        bit_d  = BIT_W'(FRAC_W);
      end
    end else if (busy_q) begin
      if (shifted >= {1'b0, den_q}) begin
        rem_d = CNT_W'(shifted - {1'b0, den_q});
        quo_d = {quo_q[FRAC_W-2:0], 1'b1};
      end else begin
        rem_d = CNT_W'(shifted);
        quo_d = {quo_q[FRAC_W-2:0], 1'b0};
      end
      bit_d = bit_q - 1'b1;
      if (bit_q == BIT_W'(1)) begin
        busy_d  = 1'b0;
        duty_d  = quo_d;
        stale_d = 1'b0;
      end
    end

    if (to_hit) begin
      busy_d  = 1'b0;
      armed_d = 1'b0;
      stale_d = 1'b1;
      duty_d  = lvl ? '1 : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
      per_q   <= '0;
      hi_q    <= '0;
      idle_q  <= '0;
      busy_q  <= 1'b0;
      rem_q   <= '0;
      den_q   <= '0;
      quo_q   <= '0;
      bit_q   <= '0;
      duty_q  <= '0;
      stale_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      armed_q <= armed_d;
      per_q   <= per_d;
      hi_q    <= hi_d;
      idle_q  <= idle_d;
      busy_q  <= busy_d;
      rem_q   <= rem_d;
      den_q   <= den_d;
      quo_q   <= quo_d;
      bit_q   <= bit_d;
      duty_q  <= duty_d;
      stale_q <= stale_d;
    end
  end

  assign duty  = duty_q;
  assign stale = stale_q;
endmodule

// File: rtl/invadp_core.sv
module invadp_core
  import invadp_pkg::*;
#(
  parameter int          CNT_W   = 24,
  parameter int          FRAC_W  = 16,
  parameter logic [31:0] TMO_RST = 32'd1_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [N_SW-1:0]   gate_in,
  output logic [N_SW-1:0]   gate_o,
  output logic              gate_en_o,
  input  logic [N_SW-1:0]   oc_n_i,
  input  logic [N_SW-1:0]   flt_n_i,
  input  logic [N_DIAG-1:0] diag_n_i,
  input  logic [N_SW-1:0]   temp_pwm_i
);
  // reset: asynchronous assertion, synchronous release
  logic rst_m_q, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_ns  <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_ns  <= rst_m_q;
    end
  end

  // control registers
  logic              ctrl_wr, tmo_wr, clr_req;
  logic              en_q, en_d;
  logic [DATA_W-1:0] tmo_q, tmo_d;
  logic [N_SW-1:0]   gate_q, gate_d;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign tmo_wr  = wr_en && (wr_addr == A_TMO);
  assign clr_req = ctrl_wr && wr_data[CTRL_CLR_BIT];

  always_comb begin
    en_d   = ctrl_wr ? wr_data[CTRL_EN_BIT] : en_q;
    tmo_d  = tmo_wr  ? wr_data : tmo_q;
    gate_d = en_d ? gate_in : '0;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      en_q   <= 1'b0;
      tmo_q  <= TMO_RST;
      gate_q <= '0;
    end else begin
      en_q   <= en_d;
      tmo_q  <= tmo_d;
      gate_q <= gate_d;
    end
  end

  assign gate_o    = gate_q;
  assign gate_en_o = en_q;

  // board flag inputs: synchronise (idle high), invert, latch
  logic [N_SW-1:0]   oc_s, flt_s, oc_act, flt_act, oc_lat, flt_lat;
  logic [N_DIAG-1:0] diag_s, diag_act, diag_lat;
  logic [N_SW-1:0]   pwm_s;

  invadp_sync #(.W(N_SW),   .RST_VAL(1'b1)) u_sync_oc   (.clk(clk), .rst_n(rst_ns), .d(oc_n_i),     .q(oc_s));
  invadp_sync #(.W(N_SW),   .RST_VAL(1'b1)) u_sync_flt  (.clk(clk), .rst_n(rst_ns), .d(flt_n_i),    .q(flt_s));
  invadp_sync #(.W(N_DIAG), .RST_VAL(1'b1)) u_sync_diag (.clk(clk), .rst_n(rst_ns), .d(diag_n_i),   .q(diag_s));
  invadp_sync #(.W(N_SW),   .RST_VAL(1'b0)) u_sync_pwm  (.clk(clk), .rst_n(rst_ns), .d(temp_pwm_i), .q(pwm_s));

  invadp_flag #(.W(N_SW),   .STICKY(1'b1)) u_flag_oc   (.clk(clk), .rst_n(rst_ns), .raw_n(oc_s),   .clr(clr_req), .act(oc_act),   .lat(oc_lat));
  invadp_flag #(.W(N_SW),   .STICKY(1'b1)) u_flag_flt  (.clk(clk), .rst_n(rst_ns), .raw_n(flt_s),  .clr(clr_req), .act(flt_act),  .lat(flt_lat));
  invadp_flag #(.W(N_DIAG), .STICKY(1'b0)) u_flag_diag (.clk(clk), .rst_n(rst_ns), .raw_n(diag_s), .clr(clr_req), .act(diag_act), .lat(diag_lat));

  logic [2*N_SW-1:0] unused_act;
  assign unused_act = {oc_act, flt_act};

  // duty meters
  logic [FRAC_W-1:0]      duty_w [N_SW];
  logic [N_SW-1:0]        stale_w;
  logic [N_SW*FRAC_W-1:0] duty_flat;

  generate
    for (genvar k = 0; k < N_SW; k++) begin : g_meter
      invadp_duty_meter #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .TMO_W(DATA_W)) u_meter (
        .clk(clk), .rst_n(rst_ns), .lvl(pwm_s[k]), .timeout(tmo_q),
        .duty(duty_w[k]), .stale(stale_w[k]));
      assign duty_flat[k*FRAC_W +: FRAC_W] = duty_w[k];
    end
  endgenerate

  // read port
  stat_word_t stat;
  always_comb begin
    stat       = '0;
    stat.oc    = oc_lat;
    stat.flt   = flt_lat;
    stat.diag  = diag_lat;
    stat.stale = stale_w;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_CTRL)      rd_data[CTRL_EN_BIT] = en_q;
    else if (rd_addr == A_TMO)  rd_data = tmo_q;
    else if (rd_addr == A_STAT) rd_data = stat;
    for (int k = 0; k < N_SW; k++) begin
      if (rd_addr == ADDR_W'(int'(A_DUTY0) + k)) rd_data = DATA_W'(duty_w[k]);
    end
  end
endmodule

// File: rtl/invadp_checker.sv
module invadp_checker
  import invadp_pkg::*;
#(
  parameter int FRAC_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_SW-1:0]        gate_o,
  input logic                   gate_en_o,
  input logic                   ctrl_wr,
  input logic [1:0]             ctrl_bits,
  input logic                   clr_req,
  input logic [2*N_SW-1:0]      lat,
  input logic [N_SW-1:0]        stale,
  input logic [N_SW*FRAC_W-1:0] duty_flat
);
  assert_gate_needs_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|gate_o) |-> gate_en_o);

  assert_en_rise_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en_o) |-> $past(ctrl_wr && ctrl_bits[0]));

  assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(lat) & ~lat)) |-> $past(clr_req));

  generate
    for (genvar k = 0; k < N_SW; k++) begin : g_ch
      logic [FRAC_W-1:0] d;
      assign d = duty_flat[k*FRAC_W +: FRAC_W];

      assert_stale_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stale[k] |-> (d == '0 || d == '1));

      assert_fresh_below_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stale[k]) |-> (d != '1));
    end
  endgenerate
endmodule

bind invadp_core invadp_checker #(.FRAC_W(FRAC_W)) i_chk (
  .clk(clk), .rst_n(rst_ns), .gate_o(gate_o), .gate_en_o(gate_en_o),
  .ctrl_wr(ctrl_wr), .ctrl_bits(wr_data[1:0]), .clr_req(clr_req),
  .lat({flt_lat, oc_lat}), .stale(stale_w), .duty_flat(duty_flat));

// File: tb/test_invadp_core.sv
module test_invadp_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [5:0]  gate_in, gate_o, oc_n_i, flt_n_i, temp_pwm_i;
  logic        gate_en_o;
  logic [3:0]  diag_n_i;

  int compared = 0;
  int mismatched = 0;

  int unsigned pwm_hi [6];
  int unsigned pwm_per[6];
  int unsigned pwm_cnt[6];
  bit          pwm_run[6];
  bit          pwm_hold[6];

  always #10 clk = ~clk;

  invadp_core i_invadp_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .gate_in(gate_in), .gate_o(gate_o),
    .gate_en_o(gate_en_o), .oc_n_i(oc_n_i), .flt_n_i(flt_n_i), .diag_n_i(diag_n_i),
    .temp_pwm_i(temp_pwm_i));

  always @(negedge clk) begin
    for (int k = 0; k < 6; k++) begin
      if (pwm_run[k]) begin
        pwm_cnt[k] = (pwm_cnt[k] + 1 >= pwm_per[k]) ? 0 : pwm_cnt[k] + 1;
        temp_pwm_i[k] = (pwm_cnt[k] < pwm_hi[k]);
      end else begin
        temp_pwm_i[k] = pwm_hold[k];
      end
    end
  end

  function automatic logic [31:0] exp_duty(int unsigned h, int unsigned p);
    longint unsigned num;
    num = longint'(h) * 65536;
    return 32'(num / p);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #2;
    d = rd_data;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [5:0]  g, pat;
    logic [3:0]  dp;
    int unsigned h, p;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 6; k++) begin
      pwm_run[k] = 1'b0; pwm_hold[k] = 1'b0; pwm_cnt[k] = 0;
      pwm_hi[k] = 1; pwm_per[k] = 2;
    end
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    gate_in = 6'h3F; oc_n_i = '1; flt_n_i = '1; diag_n_i = '1;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(8);

    // R9 reset state
    check("R9 gate_en", {31'd0, gate_en_o}, 32'd0);
    check("R9 gate_o", {26'd0, gate_o}, 32'd0);
    rd(4'd2, d); check("R9 status", d, 32'd0);
    for (int k = 0; k < 6; k++) begin
      rd(4'(3 + k), d); check("R9 duty", d, 32'd0);
    end
    rd(4'd1, d); check("R7 timeout reset", d, 32'd1_000_000);

    // R1 gates blocked while disabled
    for (int i = 0; i < 4; i++) begin
      g = 6'($urandom);
      @(negedge clk); gate_in = g;
      @(posedge clk); #1;
      check("R1 disabled gates", {26'd0, gate_o}, 32'd0);
    end

    // R2 enable and readback, R8 clear bit reads 0
    wr(4'd0, 32'h3);
    check("R2 gate_en set", {31'd0, gate_en_o}, 32'd1);
    rd(4'd0, d); check("R8 ctrl readback", d, 32'd1);

    // R1 forwarding with one clock delay
    for (int i = 0; i < 8; i++) begin
      g = 6'($urandom);
      @(negedge clk); gate_in = g;
      @(posedge clk); #1;
      check("R1 forward", {26'd0, gate_o}, {26'd0, g});
    end

    // R8 unmapped reads
    rd(4'd9, d);  check("R8 unmapped 9", d, 32'd0);
    rd(4'd15, d); check("R8 unmapped 15", d, 32'd0);

    // R7 timeout readback
    wr(4'd1, 32'd2000);
    rd(4'd1, d); check("R7 timeout write", d, 32'd2000);

    // R3 live diagnostic
    dp = 4'($urandom) | 4'h1;
    @(negedge clk); diag_n_i = ~dp;
    wait_cyc(6);
    rd(4'd2, d); check("R3 diag live", d, {16'd0, dp, 12'd0});
    @(negedge clk); diag_n_i = '1;
    wait_cyc(6);
    rd(4'd2, d); check("R3 diag release", d, 32'd0);

    // R4 one-cycle pulses latch
    pat = 6'($urandom) | 6'h01;
    g   = 6'($urandom) | 6'h20;
    @(negedge clk); oc_n_i = ~pat; flt_n_i = ~g;
    @(negedge clk); oc_n_i = '1;   flt_n_i = '1;
    wait_cyc(8);
    rd(4'd2, d); check("R4 sticky after pulse", d, {20'd0, g, pat});

    // R5 clear with one OC still asserted
    @(negedge clk); oc_n_i = 6'b111110;
    wait_cyc(6);
    wr(4'd0, 32'h3);
    wait_cyc(4);
    rd(4'd2, d); check("R5 clear keeps active", d, 32'h1);
    @(negedge clk); oc_n_i = '1;
    wait_cyc(6);
    rd(4'd2, d); check("R4 still held after release", d, 32'h1);
    wr(4'd0, 32'h3);
    wait_cyc(4);
    rd(4'd2, d); check("R5 clear", d, 32'd0);

    // R6 duty measurement with random periods
    for (int t = 0; t < 5; t++) begin
      for (int k = 0; k < 6; k++) begin
        p = 20 + ($urandom % 181);
        h = 1 + ($urandom % (p - 1));
        pwm_per[k] = p; pwm_hi[k] = h; pwm_cnt[k] = 0; pwm_run[k] = 1'b1;
      end
      wait_cyc(700);
      for (int k = 0; k < 6; k++) begin
        rd(4'(3 + k), d);
        check("R6 duty", d, exp_duty(pwm_hi[k], pwm_per[k]));
      end
      rd(4'd2, d); check("R7 no stale while toggling", d, 32'd0);
    end

    // R6 directed corners: shortest high and shortest low
    pwm_per[0] = 40; pwm_hi[0] = 1;  pwm_cnt[0] = 0;
    pwm_per[1] = 40; pwm_hi[1] = 39; pwm_cnt[1] = 0;
    wait_cyc(300);
    rd(4'd3, d); check("R6 min high", d, exp_duty(1, 40));
    rd(4'd4, d); check("R6 max high", d, exp_duty(39, 40));

    // R7 stale on stuck lines
    wr(4'd1, 32'd300);
    for (int k = 0; k < 6; k++) begin
      pwm_hold[k] = (k < 3); pwm_run[k] = 1'b0;
    end
    wait_cyc(400);
    for (int k = 0; k < 6; k++) begin
      rd(4'(3 + k), d);
      check("R7 stale level", d, (k < 3) ? 32'h0000FFFF : 32'd0);
    end
    rd(4'd2, d); check("R7 stale bits", d, 32'h003F0000);

    // R7 resume clears stale
    for (int k = 0; k < 6; k++) begin
      pwm_per[k] = 100; pwm_hi[k] = 25 + 10 * k; pwm_cnt[k] = 0; pwm_run[k] = 1'b1;
    end
    wait_cyc(700);
    rd(4'd2, d); check("R7 stale cleared", d, 32'd0);
    rd(4'd8, d); check("R6 after resume", d, exp_duty(75, 100));

    // R7 timeout 0 disables
    wr(4'd1, 32'd0);
    for (int k = 0; k < 6; k++) begin
      pwm_hold[k] = 1'b1; pwm_run[k] = 1'b0;
    end
    wait_cyc(500);
    rd(4'd2, d); check("R7 timeout disabled", d, 32'd0);
    rd(4'd3, d); check("R7 duty kept", d, exp_duty(25, 100));

    // R2 disable forces gates low
    @(negedge clk); gate_in = 6'h3F;
    wr(4'd0, 32'h0);
    @(posedge clk); #1;
    check("R2 gate_en cleared", {31'd0, gate_en_o}, 32'd0);
    check("R1 gates off after disable", {26'd0, gate_o}, 32'd0);

    finish_run();
  end
endmodule